// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

A synthesizable model of a synchronous static RAM that keeps its data bus fully busy: reads and writes can follow each other on consecutive clocks in any mix, because both kinds of operation place their data phase two clocks after the address. Address, control, chip enables, byte-lane enables and direction are all registered on the rising edge. Two edges later a read drives its word out through a registered output with an output enable, and a write samples its word from the incoming data bus. Since write data is captured late, a read issued on the clock after a write to the same word already sees the new value.

A clock-enable input freezes the whole pipeline. Three chip enables, one active high and two active low, allow depth expansion. A two-bit counter turns one loaded address into a four-word burst, in linear or interleaved order. The data bus is split into an input, an output and an output-enable, so that a pad ring can build a tri-state pin.

Top module: `zt_sram`

## Requirements
- R1: A read sampled at rising edge T, with `cen_n` low at edges T..T+2, drives the addressed word on `dq_out` with `dq_oe` high after edge T+2.
- R2: A write sampled at edge T stores the value that `dq_in` holds at edge T+2, not the value present at edge T.
- R3: Operations may be issued on every clock in any mix of directions with no idle cycle between them. A read of a word issued on the clock after a write to it returns the new data.
- R4: While `cen_n` is high, every input is ignored and the pipeline, the burst state, `dq_out` and `dq_oe` all hold. An operation requested in a stalled cycle never takes place.
- R5: When `adv_ld_n` is low and any of `ce1_n`=0, `ce2`=1, `ce3_n`=0 fails, no operation starts, a running burst ends, and `dq_oe` is low two enabled edges later. Later cycles with `adv_ld_n` high start nothing until a new load.
- R6: Operations already issued before a deselect still complete their data phase.
- R7: `dq_oe` is low after the edge at which a write takes its data.
- R8: With `burst_il`=0, beat k of a burst (k=0..3) uses the loaded address with its two low bits replaced by (low bits + k) mod 4.
- R9: With `burst_il`=1, beat k uses the loaded address with its two low bits XORed with k.
- R10: `bw_n[i]` low, sampled with the address, enables lane i (data bits 9i+8..9i at the default width) for a write. Disabled lanes keep their old contents.
- R11: Burst continuation beats (`adv_ld_n` high) take the direction of the loading cycle. `we_n` is ignored on those beats.
- R12: After reset `dq_oe` is low and no operation is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline and burst state |
| cen_n | input | 1 | Active-low clock enable; high stalls everything |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adv_ld_n | input | 1 | Low: load a new address; high: advance the burst |
| we_n | input | 1 | Low selects a write, high a read (load cycles only) |
| bw_n | input | LANES | Active-low per-lane write enables |
| burst_il | input | 1 | Static burst order: 0 linear, 1 interleaved |
| addr | input | AW | Word address |
| dq_in | input | DW | Data bus input (write data) |
| dq_out | output | DW | Registered read data |
| dq_oe | output | 1 | High while `dq_out` should drive the bus |

## Verification
The bench interleaves writes and reads to the same word on adjacent clocks. A design that captured write data at the address edge, or that read the array one stage too early, would return stale or wrong words. It stalls the clock enable while a read result is on the bus and while a write is being requested, which catches a pipeline that slips or an array that accepts the stalled write. It runs bursts from non-aligned starting addresses in both orders, and flips `we_n` during continuation beats, so that a wrong wrap, a swapped order or a burst that re-reads the direction input shows up as misplaced or overwritten words. Finally it deselects in the middle of a burst and then tries to advance, which checks that the two in-flight reads still appear and that nothing further is driven.

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int DW    = 18,
  parameter int LANES = 2,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cen_n,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             adv_ld_n,
  input  logic             we_n,
  input  logic [LANES-1:0] bw_n,
  input  logic             burst_il,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    dq_in,
  output logic [DW-1:0]    dq_out,
  output logic             dq_oe
);
  localparam int LW    = DW / LANES;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  logic          sel, load, cont;
  logic          b_act, b_wr;
  logic [AW-1:0] b_base;
  logic [1:0]    b_cnt, nxt_cnt, low2;

  logic             op_v, op_we;
  logic [AW-1:0]    op_a;
  logic             p1_v, p1_we, p2_v, p2_we;
  logic [AW-1:0]    p1_a, p2_a;
  logic [LANES-1:0] p1_bw, p2_bw;

  assign sel     = !ce1_n && ce2 && !ce3_n;
  assign load    = !adv_ld_n && sel;
  assign cont    = adv_ld_n && b_act;
  assign nxt_cnt = b_cnt + 2'd1;
  assign low2    = burst_il ? (b_base[1:0] ^ nxt_cnt) : (b_base[1:0] + nxt_cnt);
  assign op_v    = load || cont;
  assign op_we   = load ? !we_n : b_wr;
  assign op_a    = load ? addr : {b_base[AW-1:2], low2};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_act  <= 1'b0;
      b_wr   <= 1'b0;
      b_base <= '0;
      b_cnt  <= '0;
      p1_v   <= 1'b0;
      p1_we  <= 1'b0;
      p1_a   <= '0;
      p1_bw  <= '0;
      p2_v   <= 1'b0;
      p2_we  <= 1'b0;
      p2_a   <= '0;
      p2_bw  <= '0;
      dq_oe  <= 1'b0;
      dq_out <= '0;
    end else if (!cen_n) begin
      if (!adv_ld_n) begin
        b_act <= sel;
        if (sel) begin
          b_base <= addr;
          b_cnt  <= 2'd0;
          b_wr   <= !we_n;
        end
      end else if (b_act) begin
        b_cnt <= nxt_cnt;
      end
      p1_v  <= op_v;
      p1_we <= op_we;
      p1_a  <= op_a;
      p1_bw <= ~bw_n;
      p2_v  <= p1_v;
      p2_we <= p1_we;
      p2_a  <= p1_a;
      p2_bw <= p1_bw;
      dq_oe <= p2_v && !p2_we;
      if (p2_v && !p2_we) dq_out <= mem[p2_a];
    end
  end

  always_ff @(posedge clk) begin
    if (!cen_n && p2_v && p2_we) begin
      for (int i = 0; i < LANES; i++)
        if (p2_bw[i]) mem[p2_a][i*LW +: LW] <= dq_in[i*LW +: LW];
    end
  end

  p_read_oe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !adv_ld_n && sel && we_n) ##1 !cen_n ##1 !cen_n |=> dq_oe);

  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cen_n |=> ($stable(dq_oe) && $stable(dq_out)));

  p_desel_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !adv_ld_n && !sel) ##1 !cen_n ##1 !cen_n |=> !dq_oe);

  p_write_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !adv_ld_n && sel && !we_n) ##1 !cen_n ##1 !cen_n |=> !dq_oe);

  p_stall_burst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cen_n |=> ($stable(b_cnt) && $stable(b_act)));
endmodule

// File: tb/tb_zt_sram.sv
module tb_zt_sram;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cen_n = 1'b0, ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
  logic        adv_ld_n = 1'b0, we_n = 1'b1, burst_il = 1'b0;
  logic [1:0]  bw_n = 2'b11;
  logic [5:0]  addr = '0;
  logic [17:0] dq_in = '0;
  logic [17:0] dq_out;
  logic        dq_oe;
  int total = 0, bad = 0;

  zt_sram dut (.clk, .rst_n, .cen_n, .ce1_n, .ce2, .ce3_n, .adv_ld_n, .we_n,
               .bw_n, .burst_il, .addr, .dq_in, .dq_out, .dq_oe);

  always #5 clk = ~clk;

  task automatic step(input logic c, input logic ld, input logic s, input logic w,
                      input logic [5:0] a, input logic [1:0] bwn, input logic [17:0] d);
    cen_n = c; adv_ld_n = ld; we_n = w; addr = a; bw_n = bwn; dq_in = d;
    {ce1_n, ce2, ce3_n} = s ? 3'b010 : 3'b101;
    @(negedge clk);
  endtask

  task automatic ldo(input logic w, input logic [5:0] a, input logic [1:0] bwn, input logic [17:0] d);
    step(1'b0, 1'b0, 1'b1, w, a, bwn, d);
  endtask
  task automatic ds(input logic [17:0] d);
    step(1'b0, 1'b0, 1'b0, 1'b1, 6'h3F, 2'b11, d);
  endtask
  task automatic adv(input logic w, input logic [17:0] d);
    step(1'b0, 1'b1, 1'b1, w, 6'h3F, 2'b00, d);
  endtask

  task automatic chk(input string req, input logic eoe, input logic [17:0] ed);
    total++;
    if (dq_oe !== eoe || (eoe && dq_out !== ed)) begin
      bad++;
      $display("FAIL %s: got oe=%b dq=%h, expected oe=%b dq=%h", req, dq_oe, dq_out, eoe, ed);
    end
  endtask

  task automatic t_reset;
    chk("R12 reset", 1'b0, 18'h0);
    ds(0);
    chk("R12 idle", 1'b0, 18'h0);
  endtask

  task automatic t_basic;
    ldo(0, 6'h04, 2'b00, 0);
    ldo(0, 6'h05, 2'b00, 0);
    ldo(1, 6'h04, 2'b11, 18'h12345);
    chk("R7 write phase", 1'b0, 0);
    ldo(1, 6'h05, 2'b11, 18'h0ABCD);
    chk("R7 write phase", 1'b0, 0);
    ds(0);
    chk("R1 R2 read A4", 1'b1, 18'h12345);
    ds(0);
    chk("R3 read A5", 1'b1, 18'h0ABCD);
    ds(0);
    chk("R5 idle after deselect", 1'b0, 0);
    ldo(0, 6'h06, 2'b00, 18'h3FFFF);
    ldo(1, 6'h06, 2'b11, 0);
    ds(18'h2D2D2);
    ds(0);
    chk("R3 write then read same word", 1'b1, 18'h2D2D2);
  endtask

  task automatic t_lanes;
    ldo(0, 6'h07, 2'b00, 0);
    ldo(0, 6'h07, 2'b10, 0);
    ldo(1, 6'h07, 2'b11, 18'h3FFFF);
    ds(18'h00000);
    ds(0);
    chk("R10 lane0 only", 1'b1, 18'h3FE00);
    ldo(0, 6'h07, 2'b01, 0);
    ds(0);
    ds(18'h15555);
    ldo(1, 6'h07, 2'b11, 0);
    ds(0);
    ds(0);
    chk("R10 lane1 only", 1'b1, 18'h15400);
  endtask

  task automatic t_stall;
    ldo(0, 6'h08, 2'b00, 0);
    ds(0);
    ds(18'h15555);
    ldo(1, 6'h04, 2'b11, 0);
    ldo(1, 6'h08, 2'b11, 0);
    ds(0);
    chk("R1 read before stall", 1'b1, 18'h12345);
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 1'b0, 1'b1, 1'b0, 6'h08, 2'b00, 18'h2AAAA);
      chk("R4 hold during stall", 1'b1, 18'h12345);
    end
    ds(0);
    chk("R4 read resumes", 1'b1, 18'h15555);
    ldo(1, 6'h08, 2'b11, 18'h2AAAA);
    ds(18'h2AAAA);
    ds(18'h2AAAA);
    chk("R4 stalled write ignored", 1'b1, 18'h15555);
  endtask

  task automatic t_burst;
    burst_il = 1'b0;
    ldo(0, 6'h0A, 2'b00, 0);
    adv(1, 0);
    adv(1, 18'h00111);
    adv(1, 18'h00222);
    ds(18'h00333);
    ds(18'h00444);
    ldo(1, 6'h08, 2'b11, 0);
    ldo(1, 6'h09, 2'b11, 0);
    ldo(1, 6'h0A, 2'b11, 0);
    chk("R8 linear beat2 at 08", 1'b1, 18'h00333);
    ldo(1, 6'h0B, 2'b11, 0);
    chk("R8 linear beat3 at 09", 1'b1, 18'h00444);
    ds(0);
    chk("R8 R11 linear beat0 at 0A", 1'b1, 18'h00111);
    ds(0);
    chk("R8 R11 linear beat1 at 0B", 1'b1, 18'h00222);
    burst_il = 1'b1;
    ldo(1, 6'h09, 2'b11, 0);
    adv(0, 0);
    adv(0, 0);
    chk("R9 il beat0 at 09", 1'b1, 18'h00444);
    adv(0, 0);
    chk("R9 il beat1 at 08", 1'b1, 18'h00333);
    ds(0);
    chk("R9 il beat2 at 0B", 1'b1, 18'h00222);
    ds(0);
    chk("R9 il beat3 at 0A", 1'b1, 18'h00111);
    burst_il = 1'b0;
    ldo(1, 6'h0A, 2'b11, 0);
    ldo(1, 6'h0B, 2'b11, 0);
    ds(0);
    chk("R11 read burst wrote nothing 0A", 1'b1, 18'h00111);
    ds(0);
    chk("R11 read burst wrote nothing 0B", 1'b1, 18'h00222);
  endtask

  task automatic t_desel;
    burst_il = 1'b0;
    ldo(1, 6'h08, 2'b11, 0);
    adv(1, 0);
    ds(0);
    chk("R6 in-flight beat0", 1'b1, 18'h00333);
    adv(1, 0);
    chk("R6 in-flight beat1", 1'b1, 18'h00444);
    ds(0);
    chk("R5 oe low after deselect", 1'b0, 0);
    ds(0);
    chk("R5 burst stopped", 1'b0, 0);
  endtask

  initial begin
    #200000000;
    bad++; total++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_lanes();
    t_stall();
    t_burst();
    t_desel();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule